// File: doc/BRIEF.md
# Multiplexed Address/Data/Status Bus Sequencer

This block runs one external bus cycle at a time over a shared set of pins. The low pin group carries either an address or data, and the upper pin group carries either the top address bits or cycle status. A cycle passes through the states T1, T2 and T3, then zero or more wait states TW, then T4. In T1 the full address goes out on both groups. From T2 through T4 the low group carries data: the block drives it for a write and releases it for a read. Over the same states the upper group becomes a status word, and its top bit tells whether the cycle comes from the CPU or from a DMA or refresh initiator.

A requester presents an address, write data, a direction, a byte/word select and an initiator code, and holds them until the acknowledge appears. The external ready input stretches the cycle with wait states. A hold request parks the bus between cycles. Every pin group has its own output enable, and the enables go low at once during reset and throughout hold. In byte mode, write data is copied onto every byte lane. A byte read returns the lane chosen by the low address bit, zero-extended.

Top module: `muxbus_seq`

## Requirements
- R1: While `rst` is high, `ad_oe`, `ahs_oe` and `rd_valid` are low and `tstate_o` reads 0. The enables fall in the same cycle that `rst` rises, even in the middle of a bus cycle.
- R2: `tstate_o` encodes the state as 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4, 6 hold. A request seen at a clock edge in idle gives T1 after that edge, and then T2 and T3 on the next two edges.
- R3: The state leaves T3 or TW for TW on each edge where `ready_i` is low. It goes to T4 on the first edge where `ready_i` is high.
- R4: In T1, `ad_o` equals address bits 15..0, `ahs_o` equals address bits 19..16, and both enables are high.
- R5: From T2 through T4, `ahs_oe` is high, `ahs_o[2:0]` is 0, and `ahs_o[3]` is 0 for initiator code 0 (CPU) and 1 for code 1 (DMA) or code 2 (refresh).
- R6: On a write, `ad_oe` is high from T2 through T4. `ad_o` carries the write data, or, when `req_byte` is 1, write-data bits 7..0 on both bytes.
- R7: On a read, `ad_oe` is low from T2 through T4. `ad_i` is captured at the edge that ends the last T3 or TW. `rd_valid` is high for exactly the T4 cycle, with `rd_data` holding the word, or, in byte mode, `ad_i[7:0]` when address bit 0 is 0 and `ad_i[15:8]` when it is 1, zero-extended.
- R8: Hold is entered only from idle or at the end of T4, and it takes priority over a pending request. In hold both enables are low. Releasing hold returns the state to idle.
- R9: After T4, a pending request leads straight into T1. With no request pending, the state goes to idle, where both enables are low.
- R10: `req_ack` is high exactly in T1, the cycle after the request fields were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Asynchronous reset, active high |
| req_valid | input | 1 | A cycle request is pending |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single-byte transfer |
| req_init | input | 2 | Initiator: 0 CPU, 1 DMA, 2 refresh |
| req_ack | output | 1 | Request captured (high in T1) |
| ready_i | input | 1 | Ready; low inserts wait states |
| hold_i | input | 1 | Hold request; floats the bus between cycles |
| ad_o | output | 16 | Address/data pin values |
| ad_oe | output | 1 | Output enable of the address/data group |
| ad_i | input | 16 | Address/data pin input for reads |
| ahs_o | output | 4 | Upper address / status pin values |
| ahs_oe | output | 1 | Output enable of the upper group |
| rd_valid | output | 1 | Read data valid (high in T4 of a read) |
| rd_data | output | 16 | Captured read data |
| tstate_o | output | 3 | Current bus state code |

## Verification
The pin values and enables follow the registered state through combinational logic, so each one is due in the same cycle as the state code that selects it. The address is due one edge after the request is seen. The status word and the data direction are due from the second edge onward. Read data and `rd_valid` are due one edge after the ready edge that ends the wait, which places them in T4. The bench changes inputs only on falling edges and samples the outputs on the falling edge after each rising edge, so every check reads the state that exactly one rising edge produced. The reset check samples one nanosecond after `rst` rises, with no clock edge between.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5,
      ST_HOLD = 3'd6
   } tstate_e;

   typedef enum logic [1:0] {
      INIT_CPU  = 2'd0,
      INIT_DMA  = 2'd1,
      INIT_RFSH = 2'd2,
      INIT_RSVD = 2'd3
   } init_e;

   function automatic logic is_data_phase(input tstate_e s);
      return (s == ST_T2) || (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
   endfunction

endpackage

// File: rtl/muxbus_fsm.sv
module muxbus_fsm
   import muxbus_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    req_valid,
   input  logic    hold_req,
   input  logic    ready,
   output tstate_e state,
   output logic    take,
   output logic    sample
);

   tstate_e nxt;

   always_comb begin
      nxt  = state;
      take = 1'b0;
      unique case (state)
         ST_IDLE, ST_T4: begin
            if (hold_req) begin
               nxt = ST_HOLD;
            end else if (req_valid) begin
               nxt  = ST_T1;
               take = 1'b1;
            end else begin
               nxt = ST_IDLE;
            end
         end
         ST_T1:         nxt = ST_T2;
         ST_T2:         nxt = ST_T3;
         ST_T3, ST_TW:  nxt = ready ? ST_T4 : ST_TW;
         ST_HOLD:       nxt = hold_req ? ST_HOLD : ST_IDLE;
         default:       nxt = ST_IDLE;
      endcase
   end

   // the edge that closes the last T3 or TW is the read sample point
   assign sample = ((state == ST_T3) || (state == ST_TW)) && ready;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

endmodule

// File: rtl/muxbus_lanes.sv
module muxbus_lanes #(
   parameter  int DATA_W     = 16,
   parameter  bit BYTE_STEER = 1'b1,
   localparam int NLANE      = DATA_W / 8,
   localparam int LSEL_W     = (NLANE > 1) ? $clog2(NLANE) : 1
) (
   input  logic              byte_mode,
   input  logic [LSEL_W-1:0] lane_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] wbus,
   input  logic [DATA_W-1:0] rbus,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (BYTE_STEER) begin : g_steer
         for (genvar g = 0; g < NLANE; g++) begin : g_wlane
            assign wbus[g*8 +: 8] = byte_mode ? wdata[7:0] : wdata[g*8 +: 8];
         end

         logic [7:0] pick;
         always_comb begin
            pick = rbus[7:0];
            for (int k = 0; k < NLANE; k++) begin
               if (lane_sel == LSEL_W'(k)) pick = rbus[k*8 +: 8];
            end
            rdata = byte_mode ? {{(DATA_W-8){1'b0}}, pick} : rbus;
         end
      end else begin : g_pass
         logic unused_sel;
         assign unused_sel = ^{byte_mode, lane_sel};
         assign wbus  = wdata;
         assign rdata = rbus;
      end
   endgenerate

endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins
   import muxbus_pkg::*;
#(
   parameter  int ADDR_W = 20,
   parameter  int DATA_W = 16,
   localparam int STAT_W = ADDR_W - DATA_W
) (
   input  logic              rst,
   input  tstate_e           state,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wbus,
   input  logic              wr,
   input  init_e             init,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   output logic [STAT_W-1:0] ahs_o,
   output logic              ahs_oe
);

   logic addr_ph;
   logic data_ph;
   logic alt_init;

   assign addr_ph  = (state == ST_T1);
   assign data_ph  = is_data_phase(state);
   assign alt_init = (init != INIT_CPU);

   assign ad_oe  = !rst && (addr_ph || (data_ph && wr));
   assign ahs_oe = !rst && (addr_ph || data_ph);
   assign ad_o   = addr_ph ? addr[DATA_W-1:0] : wbus;

   generate
      if (STAT_W == 1) begin : g_stat1
         assign ahs_o = addr_ph ? addr[ADDR_W-1:DATA_W] : alt_init;
      end else begin : g_statn
         assign ahs_o = addr_ph ? addr[ADDR_W-1:DATA_W]
                                : {alt_init, {(STAT_W-1){1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
   import muxbus_pkg::*;
#(
   parameter  int ADDR_W     = 20,
   parameter  int DATA_W     = 16,
   parameter  bit BYTE_STEER = 1'b1,
   localparam int STAT_W     = ADDR_W - DATA_W,
   localparam int NLANE      = DATA_W / 8,
   localparam int LSEL_W     = (NLANE > 1) ? $clog2(NLANE) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_write,
   input  logic              req_byte,
   input  logic [1:0]        req_init,
   output logic              req_ack,
   input  logic              ready_i,
   input  logic              hold_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_i,
   output logic [STAT_W-1:0] ahs_o,
   output logic              ahs_oe,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [2:0]        tstate_o
);

   generate
      if ((DATA_W < 16) || (DATA_W % 8 != 0)) begin : g_bad_data_w
         $error("muxbus_seq: DATA_W must be a multiple of 8 and at least 16");
      end
      if (ADDR_W <= DATA_W) begin : g_bad_addr_w
         $error("muxbus_seq: ADDR_W must exceed DATA_W");
      end
   endgenerate

   tstate_e           state;
   logic              take;
   logic              sample;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_q;
   logic              byte_q;
   init_e             init_q;
   logic [DATA_W-1:0] wbus;
   logic [DATA_W-1:0] lane_rdata;
   logic              rd_valid_q;
   logic [DATA_W-1:0] rd_data_q;

   muxbus_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .hold_req  (hold_i),
      .ready     (ready_i),
      .state     (state),
      .take      (take),
      .sample    (sample)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
         byte_q  <= 1'b0;
         init_q  <= INIT_CPU;
      end else if (take) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         wr_q    <= req_write;
         byte_q  <= req_byte;
         init_q  <= init_e'(req_init);
      end
   end

   muxbus_lanes #(
      .DATA_W     (DATA_W),
      .BYTE_STEER (BYTE_STEER)
   ) u_lanes (
      .byte_mode (byte_q),
      .lane_sel  (addr_q[LSEL_W-1:0]),
      .wdata     (wdata_q),
      .wbus      (wbus),
      .rbus      (ad_i),
      .rdata     (lane_rdata)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= sample && !wr_q;
         if (sample && !wr_q) rd_data_q <= lane_rdata;
      end
   end

   muxbus_pins #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_pins (
      .rst    (rst),
      .state  (state),
      .addr   (addr_q),
      .wbus   (wbus),
      .wr     (wr_q),
      .init   (init_q),
      .ad_o   (ad_o),
      .ad_oe  (ad_oe),
      .ahs_o  (ahs_o),
      .ahs_oe (ahs_oe)
   );

   assign req_ack  = (state == ST_T1);
   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;
   assign tstate_o = state;

endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk
   import muxbus_pkg::*;
#(
   parameter int STAT_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        state,
   input logic              ready_i,
   input logic              ad_oe,
   input logic              ahs_oe,
   input logic [STAT_W-1:0] ahs_o,
   input logic              wr_q,
   input logic              rd_valid
);

   localparam logic [STAT_W-1:0] LOW_MASK = {1'b0, {(STAT_W-1){1'b1}}};

   logic in_data;
   logic in_wait;
   assign in_data = (state == ST_T2) || (state == ST_T3) || (state == ST_TW) || (state == ST_T4);
   assign in_wait = (state == ST_T3) || (state == ST_TW);

   p_reset_float_r1: assert property (@(posedge clk)
      rst |-> (!ad_oe && !ahs_oe && !rd_valid));

   p_t1_to_t2_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_T1) |=> (state == ST_T2));

   p_t2_to_t3_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_T2) |=> (state == ST_T3));

   p_wait_insert_r3: assert property (@(posedge clk) disable iff (rst)
      (in_wait && !ready_i) |=> (state == ST_TW));

   p_wait_end_r3: assert property (@(posedge clk) disable iff (rst)
      (in_wait && ready_i) |=> (state == ST_T4));

   p_status_low_r5: assert property (@(posedge clk) disable iff (rst)
      in_data |-> (ahs_oe && ((ahs_o & LOW_MASK) == '0)));

   p_read_float_r7: assert property (@(posedge clk) disable iff (rst)
      (in_data && !wr_q) |-> !ad_oe);

   p_rdv_in_t4_r7: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> (state == ST_T4));

   p_hold_float_r8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HOLD) |-> (!ad_oe && !ahs_oe));

   p_no_mid_hold_r8: assert property (@(posedge clk) disable iff (rst)
      ((state == ST_T1) || (state == ST_T2) || in_wait) |=> (state != ST_HOLD));

endmodule

bind muxbus_seq muxbus_seq_chk #(.STAT_W(STAT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .state    (tstate_o),
   .ready_i  (ready_i),
   .ad_oe    (ad_oe),
   .ahs_oe   (ahs_oe),
   .ahs_o    (ahs_o),
   .wr_q     (wr_q),
   .rd_valid (rd_valid)
);

// File: tb/muxbus_seq_tb.sv
`timescale 1ns/1ps
module muxbus_seq_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_write = 1'b0;
   logic        req_byte = 1'b0;
   logic [1:0]  req_init = '0;
   logic        req_ack;
   logic        ready_i = 1'b1;
   logic        hold_i = 1'b0;
   logic [15:0] ad_o;
   logic        ad_oe;
   logic [15:0] ad_i = '0;
   logic [3:0]  ahs_o;
   logic        ahs_oe;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [2:0]  tstate_o;

   always #2.5 clk = ~clk;

   muxbus_seq u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_byte(req_byte),
      .req_init(req_init), .req_ack(req_ack), .ready_i(ready_i), .hold_i(hold_i),
      .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ahs_o(ahs_o), .ahs_oe(ahs_oe),
      .rd_valid(rd_valid), .rd_data(rd_data), .tstate_o(tstate_o)
   );

   typedef struct packed {
      logic [19:0] addr;
      logic [15:0] wdata;
      logic [15:0] rin;
      logic        wr;
      logic        byt;
      logic [1:0]  init;
      logic [2:0]  waits;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{20'hA5A5A, 16'h1234, 16'h0000, 1'b1, 1'b0, 2'd0, 3'd0},
      '{20'h3C0F1, 16'h0000, 16'hBEEF, 1'b0, 1'b0, 2'd1, 3'd2},
      '{20'h12345, 16'h0000, 16'h7E81, 1'b0, 1'b1, 2'd2, 3'd1},
      '{20'h6789A, 16'h0000, 16'h7E81, 1'b0, 1'b1, 2'd0, 3'd0},
      '{20'h80002, 16'h12C3, 16'h0000, 1'b1, 1'b1, 2'd1, 3'd3},
      '{20'hFFFFF, 16'h0F0F, 16'h0000, 1'b1, 1'b0, 2'd0, 3'd1}
   };

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      req_addr  = v.addr;
      req_wdata = v.wdata;
      req_write = v.wr;
      req_byte  = v.byt;
      req_init  = v.init;
      req_valid = 1'b1;
   endtask

   function automatic logic [3:0] exp_status(input vec_t v);
      return {(v.init != 2'd0), 3'b000};
   endfunction

   function automatic logic [15:0] exp_wbus(input vec_t v);
      return v.byt ? {v.wdata[7:0], v.wdata[7:0]} : v.wdata;
   endfunction

   function automatic logic [15:0] exp_rd(input vec_t v);
      if (!v.byt)        return v.rin;
      else if (v.addr[0]) return {8'h00, v.rin[15:8]};
      else               return {8'h00, v.rin[7:0]};
   endfunction

   task automatic data_phase_chk(input vec_t v, input logic [2:0] st, input string nm);
      chk(tstate_o == st, {"R2/R3 state in ", nm}, tstate_o, st);
      chk(ahs_oe && ahs_o == exp_status(v), {"R5 status in ", nm}, {ahs_oe, ahs_o}, {1'b1, exp_status(v)});
      if (v.wr)
         chk(ad_oe && ad_o == exp_wbus(v), {"R6 write data in ", nm}, {ad_oe, ad_o}, {1'b1, exp_wbus(v)});
      else
         chk(!ad_oe, {"R7 read float in ", nm}, ad_oe, 0);
   endtask

   task automatic run_cycle(input vec_t v, input bit issued, input bit chain, input vec_t nxt);
      if (!issued) begin
         drive(v);
         @(negedge clk);
      end
      chk(tstate_o == 3'd1, "R2 T1 after request", tstate_o, 1);
      chk(req_ack, "R10 ack in T1", req_ack, 1);
      chk(ad_oe && ahs_oe && ad_o == v.addr[15:0] && ahs_o == v.addr[19:16],
          "R4 address on pins in T1", {ad_oe, ahs_oe, ahs_o, ad_o}, {2'b11, v.addr});
      req_valid = 1'b0;
      ad_i      = v.rin;
      ready_i   = (v.waits == 3'd0);
      @(negedge clk);
      data_phase_chk(v, 3'd2, "T2");
      chk(!req_ack, "R10 ack low after T1", req_ack, 0);
      @(negedge clk);
      data_phase_chk(v, 3'd3, "T3");
      for (int k = 1; k <= int'(v.waits); k++) begin
         @(negedge clk);
         data_phase_chk(v, 3'd4, "TW");
         ready_i = (k == int'(v.waits));
      end
      @(negedge clk);
      data_phase_chk(v, 3'd5, "T4");
      if (!v.wr)
         chk(rd_valid && rd_data == exp_rd(v), "R7 read data in T4", {rd_valid, rd_data}, {1'b1, exp_rd(v)});
      else
         chk(!rd_valid, "R7 no rd_valid on write", rd_valid, 0);
      ad_i    = 16'hDEAD;
      ready_i = 1'b1;
      if (chain) drive(nxt);
      @(negedge clk);
      if (!chain) begin
         chk(tstate_o == 3'd0 && !ad_oe && !ahs_oe, "R9 idle after T4, bus floated",
             {tstate_o, ad_oe, ahs_oe}, 0);
         chk(!rd_valid, "R7 rd_valid one cycle only", rd_valid, 0);
      end
   endtask

   initial begin : main
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(tstate_o == 3'd0 && !ad_oe && !ahs_oe && !rd_valid, "R1 reset state",
          {tstate_o, ad_oe, ahs_oe, rd_valid}, 0);
      rst = 1'b0;
      @(negedge clk);

      // table-driven cycles: R2..R7, R9, R10
      for (int i = 0; i < NV; i++) run_cycle(VECS[i], 1'b0, 1'b0, VECS[i]);

      // R9: back-to-back request goes straight from T4 to T1
      run_cycle(VECS[1], 1'b0, 1'b1, VECS[0]);
      chk(tstate_o == 3'd1, "R9 T4 to T1 on pending request", tstate_o, 1);
      run_cycle(VECS[0], 1'b1, 1'b0, VECS[0]);

      // R8: hold beats a pending request in idle
      hold_i = 1'b1;
      drive(VECS[3]);
      @(negedge clk);
      chk(tstate_o == 3'd6 && !ad_oe && !ahs_oe, "R8 hold priority, bus floated",
          {tstate_o, ad_oe, ahs_oe}, {3'd6, 2'b00});
      @(negedge clk);
      chk(tstate_o == 3'd6 && !req_ack, "R8 hold persists", {tstate_o, req_ack}, {3'd6, 1'b0});
      hold_i = 1'b0;
      @(negedge clk);
      chk(tstate_o == 3'd0, "R8 release to idle", tstate_o, 0);
      @(negedge clk);
      run_cycle(VECS[3], 1'b1, 1'b0, VECS[3]);

      // R8: hold raised mid-cycle waits for the end of T4
      drive(VECS[0]);
      @(negedge clk);
      chk(tstate_o == 3'd1, "R2 T1 before mid-cycle hold", tstate_o, 1);
      req_valid = 1'b0;
      hold_i    = 1'b1;
      @(negedge clk);
      chk(tstate_o == 3'd2 && ahs_oe, "R8 no hold in T2", {tstate_o, ahs_oe}, {3'd2, 1'b1});
      @(negedge clk);
      chk(tstate_o == 3'd3, "R8 no hold in T3", tstate_o, 3);
      @(negedge clk);
      chk(tstate_o == 3'd5 && ad_oe, "R8 T4 completes under hold", {tstate_o, ad_oe}, {3'd5, 1'b1});
      @(negedge clk);
      chk(tstate_o == 3'd6 && !ad_oe && !ahs_oe, "R8 hold after T4",
          {tstate_o, ad_oe, ahs_oe}, {3'd6, 2'b00});
      hold_i = 1'b0;
      @(negedge clk);

      // R1: reset in the middle of a write cycle floats the pins at once
      drive(VECS[5]);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(ad_oe && ahs_oe, "R6 write drives before reset", {ad_oe, ahs_oe}, 2'b11);
      rst = 1'b1;
      #1;
      chk(!ad_oe && !ahs_oe && tstate_o == 3'd0, "R1 asynchronous float on reset",
          {tstate_o, ad_oe, ahs_oe}, 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(tstate_o == 3'd0 && !rd_valid, "R1 idle after reset release", {tstate_o, rd_valid}, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule